// File: doc/BRIEF.md
# Indirect Register Window with Access Spacing

This block gives a host a small register file through two 16-bit locations: an address port and a data port. The host first writes a register index to the address port. It then makes one data-port access for a 16-bit register, or two for the one 32-bit register. The direction of those data accesses comes from a flag bit inside the index, not from the host strobe.

Every data-port access is checked against two minimum spacing rules, both counted in block clock cycles. An access that breaks a rule is dropped and raises a sticky error flag.

The register set has these members:
- an identification word;
- a scratch word;
- a software-reset trigger;
- a write-one-to-clear interrupt status register, fed by event inputs;
- an interrupt enable mask;
- one 32-bit holding register.

The host interface is a one-cycle strobe, `acc_valid`, with no back-pressure, because every legal access completes in the cycle it is presented. A read answers one clock later with a one-cycle `rsp_valid` pulse. The host must take that response in the same cycle, since nothing holds it.

Top module: `regwin_port`

## Requirements
- R1: The index is bits 7:0 of an address-port write, and bits 15:8 are ignored. Index bit 7 set makes the following data accesses writes. Bit 7 clear makes them reads. In both cases bits 6:0 select the register.
- R2: An accepted data-port read gives `rsp_valid` high for exactly one cycle, in the cycle after the access, with the register value on `rsp_data`. Data-port writes give no response.
- R3: A data-port access is accepted only under two conditions:
  - at least DATA_GAP_CYC = ceil(DATA_GAP_NS/CLK_PERIOD_NS) clock edges have passed since the last accepted data access;
  - at least ADDR_GAP_CYC = ceil(ADDR_GAP_NS/CLK_PERIOD_NS) edges have passed since the last address-port write.

  Otherwise the access is ignored, and `timing_err` goes high and stays high until `rst_n` is asserted.
- R4: Index 0x27 is a read-only identification word. Its upper byte is 0x61.
- R5: Index 0x28 is a 16-bit scratch register that reads back what was written.
- R6: Writing 0x00F6 to index 0x29 clears the scratch, enable, status and 32-bit registers. Writing any other value to 0x29 has no effect. Index 0x29 reads as 0.
- R7: Index 0x24 holds interrupt status. Bits 0, 1, 2, 4, 5 and 6 are set by the matching `evt_in` bits. Bit 3 and bits 15:7 always read 0. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the event wins.
- R8: Index 0x25 holds the interrupt enable bits, using the same bit positions as the status register. `irq` is high when any status bit and its enable bit are both 1.
- R9: Index 0x30 is a 32-bit register moved as two data accesses, low half first.
  - A write commits all 32 bits only on the second access.
  - A read captures the upper half on the first access, so the two halves come from one instant.
- R10: After a 16-bit access, or after both halves of a 32-bit access, the port waits for a new index. A data access with no index loaded is ignored: it gives no response and sets no flag.
- R11: An address-port write abandons any half-finished 32-bit sequence, and the 32-bit register keeps its old value.
- R12: A read of any unlisted index returns 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_addr_sel | input | 1 | 1 selects the address port, 0 selects the data port |
| acc_wdata | input | 16 | Index for an address-port write, or write data for the data port |
| evt_in | input | 7 | Interrupt event inputs, one per status bit |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | 16 | Read response data |
| irq | output | 1 | Interrupt request |
| timing_err | output | 1 | Sticky spacing-violation flag |

## Verification
The hardest situations to reach from the ports are timing coincidences. One is a 32-bit transfer broken between its halves, either by a new index or by a second access that arrives too early. The other is an event landing in the same edge as the write that clears its status bit. The stimulus reaches the first by placing an address write, or a deliberately early data access, between the low and high accesses of the 32-bit register, then reading the register back in full. It reaches the second by raising `evt_in` in the exact cycle the clearing data access is strobed. Spacing faults are then followed by a legal access to the same index, to show that a dropped access changed neither the register nor the sequence state.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int DATA_W = 16;
  localparam int EVT_W  = 7;

  localparam logic [6:0] IDX_IRQ_STAT = 7'h24;
  localparam logic [6:0] IDX_IRQ_EN   = 7'h25;
  localparam logic [6:0] IDX_ID       = 7'h27;
  localparam logic [6:0] IDX_SCRATCH  = 7'h28;
  localparam logic [6:0] IDX_SWRST    = 7'h29;
  localparam logic [6:0] IDX_WIDE     = 7'h30;

  localparam logic [DATA_W-1:0] SWRST_KEY = 16'h00F6;
  localparam logic [EVT_W-1:0]  EVT_MASK  = 7'h77;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ARMED = 2'd1,
    PS_HIGH  = 2'd2
  } port_state_e;

  function automatic logic is_wide(input logic [6:0] sel);
    return sel == IDX_WIDE;
  endfunction

endpackage

// File: rtl/regwin_gap.sv
module regwin_gap #(
  parameter int GAP_CYC = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic ok
);
  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(GAP_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= LIMIT;
    else if (hit)         cnt <= CW'(1);
    else if (cnt < LIMIT) cnt <= cnt + 1'b1;
  end

  assign ok = (cnt >= LIMIT);

  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ((GAP_CYC <= 1) || !ok)); // R3

endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
  import regwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_wr,
  input  logic [7:0] idx_in,
  input  logic       data_ok,
  output logic       armed,
  output logic       high_half,
  output logic       wr_mode,
  output logic [6:0] sel
);
  port_state_e state;
  logic [7:0]  idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_IDLE;
      idx   <= '0;
    end else if (addr_wr) begin
      idx   <= idx_in;
      state <= PS_ARMED;
    end else if (data_ok) begin
      if (state == PS_ARMED && is_wide(idx[6:0])) state <= PS_HIGH;
      else                                        state <= PS_IDLE;
    end
  end

  assign armed     = (state != PS_IDLE);
  assign high_half = (state == PS_HIGH);
  assign wr_mode   = idx[7];
  assign sel       = idx[6:0];

  AST_HIGH_ONLY_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_HIGH) |-> is_wide(idx[6:0])); // R9
  AST_ADDR_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (state == PS_ARMED)); // R11

endmodule

// File: rtl/regwin_regs.sv
module regwin_regs
  import regwin_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 16'h6113
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic [6:0]        sel,
  input  logic              high_half,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EVT_W-1:0]  evt,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [EVT_W-1:0]    stat, en, clr;
  logic [DATA_W-1:0]   scratch, stage_lo, snap_hi;
  logic [2*DATA_W-1:0] wide;
  logic                wr_hit, rd_hit, swrst;

  assign wr_hit = acc & wr;
  assign rd_hit = acc & ~wr;
  assign swrst  = wr_hit && (sel == IDX_SWRST) && (wdata == SWRST_KEY);
  assign clr    = (wr_hit && sel == IDX_IRQ_STAT) ? wdata[EVT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0; en <= '0; scratch <= '0;
      wide <= '0; stage_lo <= '0; snap_hi <= '0;
    end else if (swrst) begin
      stat <= '0; en <= '0; scratch <= '0;
      wide <= '0; stage_lo <= '0; snap_hi <= '0;
    end else begin
      stat <= (stat & ~clr) | (evt & EVT_MASK);
      if (wr_hit && sel == IDX_IRQ_EN)  en      <= wdata[EVT_W-1:0] & EVT_MASK;
      if (wr_hit && sel == IDX_SCRATCH) scratch <= wdata;
      if (wr_hit && sel == IDX_WIDE) begin
        if (!high_half) stage_lo <= wdata;
        else            wide     <= {wdata, stage_lo};
      end
      if (rd_hit && sel == IDX_WIDE && !high_half) snap_hi <= wide[2*DATA_W-1:DATA_W];
    end
  end

  always_comb begin
    case (sel)
      IDX_IRQ_STAT: rdata = {{(DATA_W-EVT_W){1'b0}}, stat};
      IDX_IRQ_EN:   rdata = {{(DATA_W-EVT_W){1'b0}}, en};
      IDX_ID:       rdata = ID_VALUE;
      IDX_SCRATCH:  rdata = scratch;
      IDX_WIDE:     rdata = high_half ? snap_hi : wide[DATA_W-1:0];
      default:      rdata = '0;
    endcase
  end

  assign irq = |(stat & en);

  AST_STAT_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~EVT_MASK) == '0); // R7
  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (scratch == '0 && en == '0 && wide == '0)); // R6

endmodule

// File: rtl/regwin_port.sv
module regwin_port
  import regwin_pkg::*;
#(
  parameter int                CLK_PERIOD_NS = 8,
  parameter int                DATA_GAP_NS   = 150,
  parameter int                ADDR_GAP_NS   = 300,
  parameter logic [DATA_W-1:0] ID_VALUE      = 16'h6113
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_addr_sel,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [EVT_W-1:0]  evt_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              irq,
  output logic              timing_err
);
  localparam int DATA_GAP_CYC = (DATA_GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int ADDR_GAP_CYC = (ADDR_GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic addr_wr, data_try, data_ok, data_gap_ok, addr_gap_ok, spacing_bad;
  logic armed, high_half, wr_mode;
  logic [6:0]        sel;
  logic [DATA_W-1:0] rdata;

  assign addr_wr     = acc_valid & acc_addr_sel;
  assign data_try    = acc_valid & ~acc_addr_sel & armed;
  assign spacing_bad = data_try & ~(data_gap_ok & addr_gap_ok);
  assign data_ok     = data_try & data_gap_ok & addr_gap_ok;

  regwin_gap #(.GAP_CYC(DATA_GAP_CYC)) u_data_gap (
    .clk(clk), .rst_n(rst_n), .hit(data_ok), .ok(data_gap_ok));

  regwin_gap #(.GAP_CYC(ADDR_GAP_CYC)) u_addr_gap (
    .clk(clk), .rst_n(rst_n), .hit(addr_wr), .ok(addr_gap_ok));

  regwin_seq u_seq (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .idx_in(acc_wdata[7:0]),
    .data_ok(data_ok), .armed(armed), .high_half(high_half),
    .wr_mode(wr_mode), .sel(sel));

  regwin_regs #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc(data_ok), .wr(wr_mode), .sel(sel),
    .high_half(high_half), .wdata(acc_wdata), .evt(evt_in),
    .rdata(rdata), .irq(irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      timing_err <= 1'b0;
    end else begin
      rsp_valid <= data_ok & ~wr_mode;
      if (data_ok & ~wr_mode) rsp_data <= rdata;
      if (spacing_bad) timing_err <= 1'b1;
    end
  end

  AST_RSP_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid && !acc_addr_sel)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> timing_err); // R3

endmodule

// File: tb/regwin_port_tb.sv
module regwin_port_tb_top;
  localparam int DG = (150 + 7) / 8;
  localparam int AG = (300 + 7) / 8;
  localparam logic [15:0] IDV = 16'h6113;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_addr_sel = 1'b0;
  logic [15:0] acc_wdata = '0;
  logic [6:0]  evt_in = '0;
  logic        rsp_valid, irq, timing_err;
  logic [15:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R2";

  always #4 clk = ~clk;

  regwin_port #(.CLK_PERIOD_NS(8), .DATA_GAP_NS(150), .ADDR_GAP_NS(300), .ID_VALUE(IDV)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr_sel(acc_addr_sel),
    .acc_wdata(acc_wdata), .evt_in(evt_in), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq(irq), .timing_err(timing_err));

  // behavioural reference model
  int          m_cyc = 0, m_ld = -1000, m_la = -1000, m_st = 0;
  logic [7:0]  m_idx = '0;
  logic [6:0]  m_stat = '0, m_en = '0, m_clr;
  logic [15:0] m_scr = '0, m_stage = '0, m_snap = '0, e_rd = '0;
  logic [31:0] m_wide = '0;
  logic        e_rv = 0, e_irq = 0, e_terr = 0, m_swr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_ld = -1000; m_la = -1000; m_st = 0; m_idx = '0;
      m_stat = '0; m_en = '0; m_scr = '0; m_stage = '0; m_snap = '0; m_wide = '0;
      e_rv = 0; e_irq = 0; e_terr = 0;
    end else begin
      m_cyc++; e_rv = 0; m_clr = '0; m_swr = 0;
      if (acc_valid && acc_addr_sel) begin
        m_idx = acc_wdata[7:0]; m_st = 1; m_la = m_cyc;
      end else if (acc_valid && m_st != 0) begin
        if (m_cyc - m_ld < DG || m_cyc - m_la < AG) e_terr = 1;
        else begin
          m_ld = m_cyc;
          if (!m_idx[7]) begin
            e_rv = 1;
            case (m_idx[6:0])
              7'h24: e_rd = {9'd0, m_stat};
              7'h25: e_rd = {9'd0, m_en};
              7'h27: e_rd = IDV;
              7'h28: e_rd = m_scr;
              7'h30: e_rd = (m_st == 2) ? m_snap : m_wide[15:0];
              default: e_rd = '0;
            endcase
            if (m_idx[6:0] == 7'h30 && m_st == 1) m_snap = m_wide[31:16];
          end else begin
            case (m_idx[6:0])
              7'h24: m_clr = acc_wdata[6:0];
              7'h25: m_en = acc_wdata[6:0] & 7'h77;
              7'h28: m_scr = acc_wdata;
              7'h29: m_swr = (acc_wdata == 16'h00F6);
              7'h30: if (m_st == 1) m_stage = acc_wdata; else m_wide = {acc_wdata, m_stage};
              default: ;
            endcase
          end
          m_st = (m_idx[6:0] == 7'h30 && m_st == 1) ? 2 : 0;
        end
      end
      if (m_swr) begin
        m_stat = '0; m_en = '0; m_scr = '0; m_wide = '0; m_stage = '0; m_snap = '0;
      end else m_stat = (m_stat & ~m_clr) | (evt_in & 7'h77);
      e_irq = |(m_stat & m_en);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (rsp_valid !== e_rv || (e_rv && rsp_data !== e_rd) ||
          irq !== e_irq || timing_err !== e_terr) begin
        n_fail++;
        $display("FAIL %s model: rv=%b data=%h irq=%b terr=%b expected rv=%b data=%h irq=%b terr=%b",
                 cur_req, rsp_valid, rsp_data, irq, timing_err, e_rv, e_rd, e_irq, e_terr);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_w(input logic [7:0] idx);
    acc_valid = 1; acc_addr_sel = 1; acc_wdata = {8'hC3, idx};
    @(negedge clk);
    acc_valid = 0; acc_addr_sel = 0;
  endtask

  task automatic data(input logic [15:0] w);
    acc_valid = 1; acc_addr_sel = 0; acc_wdata = w;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic rd16(input logic [6:0] idx, output logic [15:0] v, output logic got);
    addr_w({1'b0, idx}); idle(AG - 1); data(16'hFFFF);
    v = rsp_data; got = rsp_valid;
  endtask

  task automatic wr16(input logic [6:0] idx, input logic [15:0] v);
    addr_w({1'b1, idx}); idle(AG - 1); data(v);
  endtask

  task automatic do_reset();
    rst_n = 0; idle(3); rst_n = 1; idle(1);
  endtask

  logic [15:0] v, lo, hi;
  logic        got;

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R2 reset rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R8 reset irq", {31'd0, irq}, 0);
    chk("R3 reset timing_err", {31'd0, timing_err}, 0);

    cur_req = "R4";
    rd16(7'h27, v, got);
    chk("R4 id upper byte", {24'd0, v[15:8]}, 32'h61);
    chk("R2 read response", {31'd0, got}, 1);
    wr16(7'h27, 16'h0000);
    rd16(7'h27, v, got);
    chk("R4 id read-only", {24'd0, v[15:8]}, 32'h61);

    cur_req = "R5";
    wr16(7'h28, 16'hA5C3);
    chk("R2 no response to write", {31'd0, rsp_valid}, 0);
    rd16(7'h28, v, got);
    chk("R5 scratch readback", {16'd0, v}, 32'hA5C3);
    chk("R1 read flag keeps value", {16'd0, v}, 32'hA5C3);

    cur_req = "R10";
    idle(DG);
    data(16'h1111);
    chk("R10 no index no response", {31'd0, rsp_valid}, 0);
    chk("R10 no index no flag", {31'd0, timing_err}, 0);
    rd16(7'h28, v, got);
    chk("R10 scratch untouched", {16'd0, v}, 32'hA5C3);

    cur_req = "R9";
    addr_w(8'hB0); idle(AG - 1); data(16'h3344); idle(DG - 1); data(16'h1122);
    addr_w(8'h30); idle(AG - 1); data(0); lo = rsp_data; idle(DG - 1); data(0); hi = rsp_data;
    chk("R9 wide readback", {hi, lo}, 32'h11223344);

    cur_req = "R11";
    addr_w(8'hB0); idle(AG - 1); data(16'hDEAD);
    addr_w(8'h30); idle(AG - 1); data(0); lo = rsp_data; idle(DG - 1); data(0); hi = rsp_data;
    chk("R11 abandoned write leaves old", {hi, lo}, 32'h11223344);

    cur_req = "R12";
    rd16(7'h7F, v, got);
    chk("R12 unknown reads zero", {15'd0, got, v}, 32'h10000);
    wr16(7'h31, 16'hFFFF);
    rd16(7'h28, v, got);
    chk("R12 unknown write no effect", {16'd0, v}, 32'hA5C3);

    cur_req = "R7";
    wr16(7'h25, 16'h0012);
    evt_in = 7'h0A; @(negedge clk); evt_in = 0;
    chk("R8 irq on enabled event", {31'd0, irq}, 1);
    rd16(7'h24, v, got);
    chk("R7 bit3 masked", {16'd0, v}, 32'h0002);
    wr16(7'h24, 16'h0002);
    chk("R8 irq drops after clear", {31'd0, irq}, 0);
    evt_in = 7'h01; @(negedge clk); evt_in = 0;
    chk("R8 disabled event no irq", {31'd0, irq}, 0);
    addr_w(8'hA4); idle(AG - 1);
    evt_in = 7'h01; data(16'h0001); evt_in = 0;
    rd16(7'h24, v, got);
    chk("R7 event wins over clear", {16'd0, v}, 32'h0001);

    cur_req = "R6";
    wr16(7'h29, 16'h00F5);
    rd16(7'h28, v, got);
    chk("R6 wrong key no effect", {16'd0, v}, 32'hA5C3);
    wr16(7'h29, 16'h00F6);
    rd16(7'h28, v, got);
    chk("R6 scratch cleared", {16'd0, v}, 0);
    rd16(7'h25, v, got);
    chk("R6 enable cleared", {16'd0, v}, 0);
    rd16(7'h29, v, got);
    chk("R6 reset reg reads zero", {16'd0, v}, 0);

    cur_req = "R3";
    wr16(7'h28, 16'h5A5A);
    addr_w(8'h28); idle(2); data(0);
    chk("R3 early after addr ignored", {31'd0, rsp_valid}, 0);
    chk("R3 flag set", {31'd0, timing_err}, 1);
    idle(AG); data(0);
    chk("R3 later access accepted", {15'd0, rsp_valid, rsp_data}, 32'h15A5A);
    do_reset();
    chk("R3 flag cleared by reset", {31'd0, timing_err}, 0);
    addr_w(8'hB0); idle(AG - 1); data(16'h0BEE); idle(DG - 1); data(16'h0CAF);
    addr_w(8'h30); idle(AG - 1); data(0); lo = rsp_data;
    idle(2); data(0);
    chk("R3 early data ignored", {31'd0, rsp_valid}, 0);
    idle(DG); data(0); hi = rsp_data;
    chk("R9 high half after drop", {hi, lo}, 32'h0CAF0BEE);
    chk("R3 flag sticky", {31'd0, timing_err}, 1);

    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule